// File: doc/BRIEF.md
# Segmented Pipelined Timestamp Counter

This block keeps a wide free-running time count that several consumers in a measurement system read. A full-width increment would need a carry that ripples through every bit in a single clock. Instead, the count is cut into equal narrow segments. A segment that rolls over raises a carry, and that carry is registered, so the next segment steps one clock later. Each segment then passes through a short delay line of its own length. After those delays the three segments line up again, and consumers always see one coherent binary number. That number lags the internal state by a fixed two clocks.

A prescaler divides the input clock. It counts from zero up to a divider parameter, inclusive, and then returns to zero. The counter steps only on the prescaler's terminal cycle, and only if the enable input is high on that cycle. A synchronous load port presets the count. The load value travels through the same skew so that it also appears on the output as one coherent value. When the full count rolls over from all ones to zero, a one-cycle pulse marks the rollover on the output.

Top module: `seg_timestamp_counter`

## Requirements
- R1: While `rst_n` is low, which acts asynchronously, `count_o` reads zero, `wrap_o` reads zero and the prescaler is cleared.
- R2: With `en` held high, the count advances by one every DIV+1 clocks. DIV defaults to 5. After reset is released, the first step happens on clock edge DIV+1, and it appears on `count_o` two edges later.
- R3: A prescaler terminal cycle with `en` low leaves the count unchanged. The prescaler keeps running either way.
- R4: `count_o` equals the internal count of two clocks earlier, as one full binary value. Outside a load, it changes only by exactly +1, including across the segment boundaries at bits 14 and 28.
- R5: When `load` is high at a clock edge, the count takes `load_val` at that edge, and a coinciding step is dropped. The loaded value is first seen on `count_o` after the second following edge.
- R6: Stepping from all ones rolls the count over to zero, with no overflow flag. `wrap_o` is high for exactly the one cycle in which `count_o` first shows that zero.
- R7: The count is WIDTH bits wide (default 42) and is built from SEGS equal segments (default 3 segments of 14 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable, sampled on the prescaler terminal cycle |
| load | input | 1 | Synchronous preset strobe |
| load_val | input | WIDTH | Preset value |
| count_o | output | WIDTH | Aligned count, two clocks behind the internal state |
| wrap_o | output | 1 | One-cycle rollover pulse, aligned with `count_o` |

## Verification
The bench presets the count just below each segment boundary and just below the full rollover. This shows whether a registered carry reaches the next segment on the right clock and whether the realigned output ever shows a torn value. Runs from an arbitrary mid-range value, and runs with enable low, separate genuine stepping from stalls and from spurious carries. Directed cases pin the exact clock of the first step after reset, the two-edge visibility of a preset, and the single rollover pulse.

// File: rtl/seg_timestamp_counter.sv
`timescale 1ns/1ps
module seg_timestamp_counter #(
  parameter int WIDTH = 42,
  parameter int SEGS  = 3,
  parameter int DIV   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count_o,
  output logic             wrap_o
);
  localparam int SEG_W = WIDTH / SEGS;
  localparam int TOP   = SEGS - 1;
  localparam int PW    = (DIV > 0) ? $clog2(DIV + 1) : 1;

  logic [PW-1:0]    pre;
  logic             tick;
  logic [SEGS-1:0]  ld_q;
  logic [WIDTH-1:0] lv_q [SEGS-1];
  logic [SEG_W-1:0] seg [SEGS];
  logic [SEGS-1:1]  cy_q;
  logic             wrap_q;

  assign tick   = en && (pre == PW'(DIV));
  assign wrap_o = wrap_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= (pre == PW'(DIV)) ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld_q <= '0;
      for (int i = 0; i < SEGS - 1; i++) lv_q[i] <= '0;
    end else begin
      ld_q    <= {ld_q[SEGS-2:0], load};
      lv_q[0] <= load_val;
      for (int i = 1; i < SEGS - 1; i++) lv_q[i] <= lv_q[i-1];
    end

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    logic             inc, ld;
    logic [SEG_W-1:0] ldv;

    if (k == 0) begin : g_lo
      assign inc = tick;
      assign ld  = load;
      assign ldv = load_val[SEG_W-1:0];
    end else begin : g_hi
      assign inc = cy_q[k];
      assign ld  = ld_q[k-1];
      assign ldv = lv_q[k-1][k*SEG_W +: SEG_W];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   seg[k] <= '0;
      else if (ld)  seg[k] <= ldv;
      else if (inc) seg[k] <= seg[k] + 1'b1;

    if (k < TOP) begin : g_cy
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cy_q[k+1] <= 1'b0;
        else        cy_q[k+1] <= !ld && inc && (&seg[k]);
    end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) wrap_q <= 1'b0;
        else        wrap_q <= !ld && inc && (&seg[k]);
    end

    localparam int D = TOP - k;
    if (D == 0) begin : g_nodly
      assign count_o[k*SEG_W +: SEG_W] = seg[k];
    end else begin : g_dly
      logic [SEG_W-1:0] dl [D];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          for (int j = 0; j < D; j++) dl[j] <= '0;
        end else begin
          dl[0] <= seg[k];
          for (int j = 1; j < D; j++) dl[j] <= dl[j-1];
        end
      assign count_o[k*SEG_W +: SEG_W] = dl[D-1];
    end
  end

  assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && (pre == PW'(DIV)) && !load |=> seg[0] == $past(seg[0]) + 1'b1);

  assert_hold_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !load |=> $stable(seg[0]));

  assert_coherent_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_q[TOP] |-> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

  assert_load_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> seg[0] == $past(load_val[SEG_W-1:0]));

  assert_wrap_shows_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> count_o == '0);

  assert_wrap_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o);
endmodule

// File: tb/seg_timestamp_counter_tb.sv
`timescale 1ns/1ps
module seg_timestamp_counter_tb;
  localparam int W   = 42;
  localparam int DIV = 5;
  localparam int VW  = W + 12 + 1;
  localparam int NV  = 6;
  localparam logic [VW-1:0] VEC [NV] = '{
    {42'h000_0000_3FFD, 12'd60, 1'b1},
    {42'h000_0FFF_FFFD, 12'd60, 1'b1},
    {42'h3FF_FFFF_FFFD, 12'd60, 1'b1},
    {42'h155_5555_5555, 12'd40, 1'b0},
    {42'h0AA_AAAF_FFFE, 12'd60, 1'b1},
    {42'h3FF_FFFF_C000, 12'd30, 1'b1}
  };

  logic clk = 0, rst_n = 0, en = 0, load = 0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count_o;
  logic wrap_o;
  int nchk = 0, nfail = 0, wraps = 0;

  always #5 clk = ~clk;

  seg_timestamp_counter u_dut (.clk(clk), .rst_n(rst_n), .en(en), .load(load),
    .load_val(load_val), .count_o(count_o), .wrap_o(wrap_o));

  int unsigned pm;
  logic [W-1:0] cm, h1, h2;
  logic wm0, wm1, wm2;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pm <= 0; cm <= '0; h1 <= '0; h2 <= '0; wm0 <= 0; wm1 <= 0; wm2 <= 0;
    end else begin
      pm <= (pm == DIV) ? 0 : pm + 1;
      if (load) cm <= load_val;
      else if (en && pm == DIV) cm <= cm + 1'b1;
      wm0 <= !load && en && pm == DIV && (&cm);
      h1 <= cm; h2 <= h1; wm1 <= wm0; wm2 <= wm1;
    end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step_model(string req);
    @(negedge clk);
    if (wrap_o) wraps++;
    chk(req, count_o, h2);
    chk("R6", W'(wrap_o), W'(wm2));
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [W-1:0] hold, x;
    en = 1;
    repeat (3) @(negedge clk);
    chk("R1", count_o, '0);
    chk("R1", W'(wrap_o), '0);
    chk("R7", W'($bits(count_o)), W'(42));
    rst_n = 1;
    for (int e = 1; e <= 14; e++) begin
      @(negedge clk);
      chk("R2", count_o, (e < 8) ? W'(0) : (e < 14) ? W'(1) : W'(2));
    end

    for (int v = 0; v < NV; v++) begin
      load = 1; load_val = VEC[v][VW-1 -: W]; en = VEC[v][0];
      step_model("R5");
      load = 0;
      step_model("R5");
      step_model("R5");
      hold = count_o;
      for (int c = 0; c < int'(VEC[v][12:1]); c++) step_model("R4");
      if (!VEC[v][0]) chk("R3", count_o, hold);
    end
    chk("R6", W'(wraps), W'(1));

    en = 0;
    repeat (3) step_model("R3");
    hold = count_o;
    x = 42'h2A5_0000_1234;
    load = 1; load_val = x;
    @(negedge clk); load = 0;
    chk("R5", count_o, hold);
    @(negedge clk);
    chk("R5", count_o, hold);
    @(negedge clk);
    chk("R5", count_o, x);
    repeat (30) step_model("R3");
    chk("R3", count_o, x);

    en = 1;
    repeat (50) step_model("R4");
    #3 rst_n = 0;
    @(negedge clk);
    chk("R1", count_o, '0);
    chk("R1", W'(wrap_o), '0);
    rst_n = 1;
    repeat (20) step_model("R2");

    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule